// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on a single output line. It runs on the system clock. An enable pulse at sixteen times the bit rate sets the bit timing. Every frame opens with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, and the frame closes with a high stop interval. The line stays high while no frame is being sent.

The frame format is held in a format register that software can only write. The register holds four settings:
- the character length: 5, 6, 7 or 8 bits
- whether parity is generated
- whether parity is odd or even
- the length of the stop interval: one bit, one and a half bits, or two bits

The one-and-a-half-bit stop interval needs half-bit timing taken from the 16x enable. It is honoured only for 5-bit characters. A load strobe hands over a character when the transmitter is idle. A busy output covers the whole frame, including the stop interval. The format is copied when a character is loaded, so a write to the format register during a frame affects only the frames that follow.

Top module: `frame_tx`

## Requirements
- R1: After reset `txLine` is 1 and `busy` is 0, and `txLine` stays 1 whenever `busy` is 0. The reset value of the format register is 8 data bits, no parity and one stop bit.
- R2: If `loadReq` is 1 at a clock edge while `busy` is 0, a frame starts. From the next cycle on, `busy` is 1 and `txLine` is 0, which is the start bit.
- R3: The start bit, each data bit and the parity bit each last exactly 16 `tick16` pulses. Between tick pulses, `txLine` changes only at the moment a frame starts.
- R4: Data bits are sent least significant bit first. `cfgWord[1:0]` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `loadData` above the selected length are not sent.
- R5: If `cfgWord[2]` is 1, a parity bit follows the last data bit. With `cfgWord[3]` at 1 the parity is odd: the data bits plus the parity bit hold an odd number of ones. With `cfgWord[3]` at 0 that count is even. If `cfgWord[2]` is 0, no parity bit is sent.
- R6: `cfgWord[5:4]` selects the stop interval, during which `txLine` is high. 00 gives 16 ticks. 10 and 11 give 32 ticks. 01 gives 24 ticks with a 5-bit character and 32 ticks with any other length.
- R7: `busy` stays 1 until the last tick of the stop interval. It falls on the clock edge that consumes that tick.
- R8: A `loadReq` while `busy` is 1 is ignored. The current frame is unchanged and no further frame follows it.
- R9: `cfgWord` is written into the format register on any edge where `cfgWrite` is 1. Each frame uses the format held in the register when its load is accepted, so a write during a frame applies to the next frame only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| cfgWrite | input | 1 | Write strobe for the format register |
| cfgWord | input | 6 | Format: [5:4] stop select, [3] odd parity, [2] parity enable, [1:0] length code |
| loadReq | input | 1 | Request to send `loadData` |
| loadData | input | DATA_W | Character to send |
| txLine | output | 1 | Serial output line, high when idle |
| busy | output | 1 | High from an accepted load to the end of the stop interval |

## Verification
The hardest cases to reach are the ones that stimulus can only cause in the middle of a frame. One is a load request that must be ignored. Another is a format write that must not change the frame already being sent. The bench tracks each bit of the expected frame by counting tick pulses. At a chosen tick inside the third bit it raises `loadReq` with different data, together with `cfgWrite` carrying a new format. It then checks three things: the current frame is sent without change, the line stays idle afterwards, and the next frame uses the new format. The 1.5-bit stop setting is tested both with a 5-bit character and with a 6-bit character, so both the 24-tick and the 32-tick results are covered.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  // Format register layout: [5:4] stop select, [3] odd, [2] parity enable, [1:0] length
  typedef struct packed {
    logic [1:0] stopSel;
    logic       parOdd;
    logic       parEn;
    logic [1:0] lenCode;
  } fmt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } txState_t;

  typedef enum logic [1:0] {
    LN_HIGH,
    LN_LOW,
    LN_DATA,
    LN_PAR
  } lineSel_t;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_t lineSel;
  } txStrobe_t;

endpackage

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int TPB    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       cfgWrite,
  input  fmt_t       cfgWord,
  input  logic       loadReq,
  output logic [1:0] liveLenCode,
  output logic       liveParOdd,
  output txStrobe_t  strb,
  output logic       busy
);

  localparam int MIN_LEN = DATA_W - 3;
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int CNT_W   = $clog2(2 * TPB + 1);

  fmt_t             fmtLive;
  fmt_t             fmtFrm;
  txState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitIdx;
  logic [BIT_W:0]   dataLen;
  logic [CNT_W-1:0] stopTicks;
  logic [CNT_W-1:0] phaseLimit;
  logic             phaseEnd;
  logic             lastBit;

  assign liveLenCode = fmtLive.lenCode;
  assign liveParOdd  = fmtLive.parOdd;
  assign busy        = (state != ST_IDLE);

  assign dataLen = (BIT_W+1)'(MIN_LEN) + {{(BIT_W-1){1'b0}}, fmtFrm.lenCode};
  assign lastBit = ({1'b0, bitIdx} == dataLen - 1'b1);

  always_comb begin
    case (fmtFrm.stopSel)
      2'b00:   stopTicks = CNT_W'(TPB);
      2'b01:   stopTicks = (fmtFrm.lenCode == 2'b00) ? CNT_W'(TPB + TPB / 2) : CNT_W'(2 * TPB);
      default: stopTicks = CNT_W'(2 * TPB);
    endcase
  end

  assign phaseLimit = (state == ST_STOP) ? stopTicks : CNT_W'(TPB);
  assign phaseEnd   = tick16 && (tickCnt == phaseLimit - 1'b1);

  always_comb begin
    strb.load  = (state == ST_IDLE) && loadReq;
    strb.shift = (state == ST_DATA) && phaseEnd;
    case (state)
      ST_START: strb.lineSel = LN_LOW;
      ST_DATA:  strb.lineSel = LN_DATA;
      ST_PAR:   strb.lineSel = LN_PAR;
      default:  strb.lineSel = LN_HIGH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtLive <= fmt_t'(6'b00_0_0_11);
      fmtFrm  <= fmt_t'(6'b00_0_0_11);
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      if (cfgWrite) fmtLive <= cfgWord;
      if (state != ST_IDLE && tick16) tickCnt <= phaseEnd ? '0 : tickCnt + 1'b1;
      case (state)
        ST_IDLE: if (loadReq) begin
          state   <= ST_START;
          fmtFrm  <= fmtLive;
          tickCnt <= '0;
          bitIdx  <= '0;
        end
        ST_START: if (phaseEnd) state <= ST_DATA;
        ST_DATA: if (phaseEnd) begin
          if (lastBit) state <= fmtFrm.parEn ? ST_PAR : ST_STOP;
          else         bitIdx <= bitIdx + 1'b1;
        end
        ST_PAR:  if (phaseEnd) state <= ST_STOP;
        ST_STOP: if (phaseEnd) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !busy) |=> busy) else $error("load not accepted"); // R2

  AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(tick16)) else $error("busy fell without tick"); // R7

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < CNT_W'(2 * TPB)) else $error("tick count overran"); // R6

endmodule

// File: rtl/frame_tx_dp.sv
module frame_tx_dp
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [1:0]        lenCode,
  input  logic              parOdd,
  input  logic [DATA_W-1:0] loadData,
  output logic              txLine
);

  localparam int MIN_LEN = DATA_W - 3;

  logic [DATA_W-1:0] lenMask;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) lenMask[i] = (i < MIN_LEN + int'(lenCode));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= loadData & lenMask;
      parBit   <= (^(loadData & lenMask)) ^ parOdd;
    end else if (strb.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    case (strb.lineSel)
      LN_LOW:  txLine = 1'b0;
      LN_DATA: txLine = shiftReg[0];
      LN_PAR:  txLine = parBit;
      default: txLine = 1'b1;
    endcase
  end

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int TPB    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              cfgWrite,
  input  logic [5:0]        cfgWord,
  input  logic              loadReq,
  input  logic [DATA_W-1:0] loadData,
  output logic              txLine,
  output logic              busy
);

  txStrobe_t  strb;
  logic [1:0] liveLenCode;
  logic       liveParOdd;

  frame_tx_ctrl #(.TPB(TPB), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick16      (tick16),
    .cfgWrite    (cfgWrite),
    .cfgWord     (fmt_t'(cfgWord)),
    .loadReq     (loadReq),
    .liveLenCode (liveLenCode),
    .liveParOdd  (liveParOdd),
    .strb        (strb),
    .busy        (busy)
  );

  frame_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lenCode  (liveLenCode),
    .parOdd   (liveParOdd),
    .loadData (loadData),
    .txLine   (txLine)
  );

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine) else $error("line low while idle"); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine) else $error("no start bit"); // R2

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(tick16)) |-> $stable(txLine)) else $error("line moved off tick"); // R3

endmodule

// File: tb/frame_tx_tb.sv
`timescale 1ns/1ps
module frame_tx_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [5:0] cfgWord = '0;
  logic       loadReq = 1'b0;
  logic [7:0] loadData = '0;
  logic       txLine;
  logic       busy;

  int testCnt = 0;
  int failCnt = 0;
  int divCnt = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 4;
    tick16 = (divCnt == 0);
  end

  frame_tx u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .loadReq(loadReq), .loadData(loadData), .txLine(txLine), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] mkFmt(input logic [1:0] stopSel, input bit odd, input bit en,
                                       input logic [1:0] len);
    return {stopSel, odd, en, len};
  endfunction

  task automatic writeFmt(input logic [5:0] f);
    @(negedge clk); #1;
    cfgWrite = 1'b1; cfgWord = f;
    @(negedge clk); #1;
    cfgWrite = 1'b0;
  endtask

  // Sends one frame and checks it tick by tick; optionally injects a load and a format write in bit 2
  task automatic runFrame(input logic [7:0] d, input logic [5:0] f, input string req,
                          input bit inject, input logic [5:0] newFmt);
    logic lvl [0:11];
    int   dur [0:11];
    int   n = 0;
    int   len = 5 + int'(f[1:0]);
    logic par = 1'b0;
    int   stopT;
    lvl[n] = 1'b0; dur[n] = 16; n++;
    for (int i = 0; i < len; i++) begin
      lvl[n] = d[i]; dur[n] = 16; n++;
      par ^= d[i];
    end
    if (f[2]) begin lvl[n] = par ^ f[3]; dur[n] = 16; n++; end
    case (f[5:4])
      2'b00:   stopT = 16;
      2'b01:   stopT = (f[1:0] == 2'b00) ? 24 : 32;
      default: stopT = 32;
    endcase
    lvl[n] = 1'b1; dur[n] = stopT; n++;

    @(negedge clk); #1;
    loadReq = 1'b1; loadData = d;
    @(negedge clk); #1;
    loadReq = 1'b0;
    check(busy === 1'b1 && txLine === 1'b0, {"R2 start ", req}, int'({busy, txLine}), 2);
    for (int k = 0; k < n; k++) begin
      int errs = 0;
      for (int t = 0; t < dur[k]; t++) begin
        while (!tick16) begin @(negedge clk); #1; end
        if (txLine !== lvl[k] || busy !== 1'b1) errs++;
        if (inject && k == 2 && t == 5) begin
          loadReq = 1'b1; loadData = ~d; cfgWrite = 1'b1; cfgWord = newFmt;
        end else begin
          loadReq = 1'b0; cfgWrite = 1'b0;
        end
        @(negedge clk); #1;
        loadReq = 1'b0; cfgWrite = 1'b0;
      end
      check(errs == 0, {"R3/R4/R5/R6 bit ", req}, errs, 0);
    end
    check(busy === 1'b0 && txLine === 1'b1, {"R7 end ", req}, int'({busy, txLine}), 1);
  endtask

  task automatic testReset();
    check(txLine === 1'b1 && busy === 1'b0, "R1 reset", int'({busy, txLine}), 1);
  endtask

  task automatic testIgnoredLoad();
    int errs = 0;
    logic [5:0] first = mkFmt(2'b00, 1'b0, 1'b0, 2'b11);
    logic [5:0] second = mkFmt(2'b10, 1'b1, 1'b1, 2'b01);
    writeFmt(first);
    runFrame(8'h5A, first, "R8 R9 frame with injection", 1'b1, second);
    for (int c = 0; c < 80; c++) begin
      @(negedge clk); #1;
      if (busy !== 1'b0 || txLine !== 1'b1) errs++;
    end
    check(errs == 0, "R8 no frame after ignored load", errs, 0);
    runFrame(8'h2D, second, "R9 next frame new format", 1'b0, 6'd0);
  endtask

  initial begin
    #(4 * 150000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    @(negedge clk); #1;
    check(txLine === 1'b1 && busy === 1'b0, "R1 after release", int'({busy, txLine}), 1);
    // reset format: 8 data bits, no parity, one stop
    runFrame(8'hA5, mkFmt(2'b00, 1'b0, 1'b0, 2'b11), "R1 R4 default 8N1", 1'b0, 6'd0);
    writeFmt(mkFmt(2'b00, 1'b0, 1'b1, 2'b00));
    runFrame(8'hFF, mkFmt(2'b00, 1'b0, 1'b1, 2'b00), "R4 R5 5E1 upper dropped", 1'b0, 6'd0);
    writeFmt(mkFmt(2'b10, 1'b1, 1'b1, 2'b10));
    runFrame(8'h3C, mkFmt(2'b10, 1'b1, 1'b1, 2'b10), "R5 R6 7O2", 1'b0, 6'd0);
    writeFmt(mkFmt(2'b01, 1'b1, 1'b1, 2'b00));
    runFrame(8'h13, mkFmt(2'b01, 1'b1, 1'b1, 2'b00), "R6 5-bit 1.5 stop", 1'b0, 6'd0);
    writeFmt(mkFmt(2'b01, 1'b0, 1'b0, 2'b01));
    runFrame(8'h2A, mkFmt(2'b01, 1'b0, 1'b0, 2'b01), "R6 6-bit 1.5 becomes 2", 1'b0, 6'd0);
    runFrame(8'h01, mkFmt(2'b01, 1'b0, 1'b0, 2'b01), "R7 back to back", 1'b0, 6'd0);
    testIgnoredLoad();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule